// File: doc/BRIEF.md
# Parallel Flash Write Sequencer

This block lets an on-chip requester program one word or erase a parallel NOR flash device without knowing anything about its command protocol. The requester hands over an operation code, a target address and a data word with a valid/ready handshake. The sequencer then drives the flash pins directly: chip enable, output enable, write enable, a 16-bit address and a 16-bit data bus whose input and output halves are kept apart.

It emits the unlock writes and the command writes that the operation needs. Every strobe phase lasts a fixed number of system clock cycles, and each count is a parameter, so the cycle counts can be matched to the clock frequency. When the last write is done, the sequencer reads one address over and over and watches bit 6. That bit alternates between reads while the device is busy. The sequencer counts the operation as finished when two reads in a row return the same bit 6.

A cycle budget limits how long polling may run. The result comes back as a one-cycle done pulse, with an error flag raised in the same cycle if the budget ran out.

Top module: `flash_write_seq`

## Requirements
- R1: While reset is held, and afterwards until a request arrives, req_ready_o is 1, flash_ce_no, flash_oe_no and flash_we_no are all 1, flash_dq_oe_o is 0, and done_o and err_o are 0.
- R2: Operation code 2'b00 (word program) issues exactly four writes, in this order: 00AAh to 5555h, 0055h to 2AAAh, 00A0h to 5555h, then the request data to the request address.
- R3: Operation code 2'b01 (main-array erase) issues exactly six writes, in this order: 00AAh/5555h, 0055h/2AAAh, 0080h/5555h, 00AAh/5555h, 0055h/2AAAh, then 0030h/5555h.
- R4: Operation codes 2'b10 and 2'b11 (full erase) issue the same six writes as R3, except that the last data word is 0010h.
- R5: In each write, flash_we_no is low for exactly WE_LOW_CYC cycles, with flash_ce_no low and flash_oe_no high. Address and data stay constant for as long as flash_we_no is low.
- R6: Between two writes of one operation, flash_we_no stays high for at least WE_HIGH_CYC cycles.
- R7: Once the writes are done, the sequencer issues status reads only. Each read has flash_oe_no and flash_ce_no low for exactly OE_LOW_CYC cycles, at the request address. Between reads, flash_oe_no stays high for at least OE_HIGH_CYC cycles. The data bus is never driven while flash_oe_no is low.
- R8: The sequencer finishes the first time two consecutive status reads return the same bit 6. It then gives a one-cycle done_o pulse with err_o at 0, and no further reads follow. If the device reports busy for N reads, the total number of reads is N+1, and never less than 2.
- R9: If polling lasts TIMEOUT_CYC cycles without finishing, the sequencer stops polling and pulses done_o with err_o set to 1 in the same cycle. err_o is never 1 without done_o.
- R10: req_ready_o is 1 only while the sequencer is idle. A request is taken when req_valid_i and req_ready_o are both 1. req_valid_i and the request fields are ignored while an operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| req_op_i | input | 2 | 00 program, 01 main-array erase, 1x full erase |
| req_addr_i | input | AW | Program target and status-poll address |
| req_data_i | input | DW | Word to program |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Set with done_o when polling timed out |
| flash_addr_o | output | AW | Flash address bus |
| flash_dq_o | output | DW | Flash write data |
| flash_dq_oe_o | output | 1 | Drive enable for flash_dq_o |
| flash_dq_i | input | DW | Flash read data |
| flash_ce_no | output | 1 | Flash chip enable, active low |
| flash_oe_no | output | 1 | Flash output enable, active low |
| flash_we_no | output | 1 | Flash write enable, active low |

## Verification
The assertions assume that flash_dq_i is stable from the second cycle of each read phase until the sample edge at its end. They also assume that the requester never needs a request taken while req_ready_o is low. The bench flash model changes its read data only on the first cycle it sees output enable low, and it toggles bit 6 only for a programmed number of busy reads. The requester holds req_valid_i high with changed fields during a busy operation to show that the extra request is dropped. The timeout case uses a small TIMEOUT_CYC with a busy count far beyond it, so the error path is reached.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WLO, S_WHI, S_RHI, S_RLO
  } seq_state_e;

  localparam logic [1:0] OP_PROG = 2'b00;
  localparam logic [1:0] OP_MAIN = 2'b01;
  localparam int unsigned STEP_W = 3;
endpackage

// File: rtl/flash_phase_timer.sv
module flash_phase_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] len_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (start_i)           cnt_q <= len_i - W'(1);
    else if (cnt_q != '0)       cnt_q <= cnt_q - W'(1);
  end

  assign last_o = (cnt_q == '0);

  // R5
  len_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (len_i != '0));
endmodule

// File: rtl/flash_cmd_step.sv
module flash_cmd_step
  import flash_seq_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16
) (
  input  logic [1:0]        op_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [AW-1:0]     tgt_addr_i,
  input  logic [DW-1:0]     tgt_data_i,
  output logic [AW-1:0]     addr_o,
  output logic [DW-1:0]     data_o,
  output logic              last_o
);
  localparam logic [AW-1:0] ADDR_U1 = AW'(16'h5555);
  localparam logic [AW-1:0] ADDR_U2 = AW'(16'h2AAA);

  logic is_prog;
  assign is_prog = (op_i == OP_PROG);

  always_comb begin
    addr_o = ADDR_U1;
    data_o = '0;
    last_o = 1'b0;
    case (step_i)
      3'd0: data_o = DW'(8'hAA);
      3'd1: begin addr_o = ADDR_U2; data_o = DW'(8'h55); end
      3'd2: data_o = is_prog ? DW'(8'hA0) : DW'(8'h80);
      3'd3: begin
        if (is_prog) begin
          addr_o = tgt_addr_i;
          data_o = tgt_data_i;
          last_o = 1'b1;
        end else begin
          data_o = DW'(8'hAA);
        end
      end
      3'd4: begin addr_o = ADDR_U2; data_o = DW'(8'h55); end
      3'd5: begin
        data_o = (op_i == OP_MAIN) ? DW'(8'h30) : DW'(8'h10);
        last_o = 1'b1;
      end
      default: last_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/flash_write_seq.sv
module flash_write_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned AW          = 16,
  parameter int unsigned DW          = 16,
  parameter int unsigned WE_LOW_CYC  = 4,
  parameter int unsigned WE_HIGH_CYC = 3,
  parameter int unsigned OE_LOW_CYC  = 3,
  parameter int unsigned OE_HIGH_CYC = 8,
  parameter int unsigned TIMEOUT_CYC = 260_000_000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  output logic          done_o,
  output logic          err_o,
  output logic [AW-1:0] flash_addr_o,
  output logic [DW-1:0] flash_dq_o,
  output logic          flash_dq_oe_o,
  input  logic [DW-1:0] flash_dq_i,
  output logic          flash_ce_no,
  output logic          flash_oe_no,
  output logic          flash_we_no
);
  localparam int unsigned PH_W = 8;
  localparam int unsigned TO_W = $clog2(TIMEOUT_CYC + 1);

  seq_state_e        state_q, state_d;
  logic [1:0]        op_q;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     data_q;
  logic [STEP_W-1:0] step_q;
  logic              prev6_q, have_prev_q, done_q, err_q;
  logic              fin_ok, fin_err;
  logic              ph_last, to_last, to_start;
  logic [PH_W-1:0]   ph_len;
  logic [AW-1:0]     step_addr;
  logic [DW-1:0]     step_data;
  logic              step_last;

  flash_cmd_step #(.AW(AW), .DW(DW)) u_step (
    .op_i(op_q), .step_i(step_q), .tgt_addr_i(addr_q), .tgt_data_i(data_q),
    .addr_o(step_addr), .data_o(step_data), .last_o(step_last)
  );

  always_comb begin
    case (state_d)
      S_WLO:   ph_len = PH_W'(WE_LOW_CYC);
      S_WHI:   ph_len = PH_W'(WE_HIGH_CYC);
      S_RHI:   ph_len = PH_W'(OE_HIGH_CYC);
      S_RLO:   ph_len = PH_W'(OE_LOW_CYC);
      default: ph_len = PH_W'(1);
    endcase
  end

  flash_phase_timer #(.W(PH_W)) u_phase (
    .clk_i, .rst_ni, .start_i(state_d != state_q), .len_i(ph_len), .last_o(ph_last)
  );

  assign to_start = (state_q == S_WHI) && (state_d == S_RHI);

  flash_phase_timer #(.W(TO_W)) u_timeout (
    .clk_i, .rst_ni, .start_i(to_start), .len_i(TO_W'(TIMEOUT_CYC)), .last_o(to_last)
  );

  always_comb begin
    state_d = state_q;
    fin_ok  = 1'b0;
    fin_err = 1'b0;
    case (state_q)
      S_IDLE: if (req_valid_i) state_d = S_WLO;
      S_WLO:  if (ph_last) state_d = S_WHI;
      S_WHI:  if (ph_last) state_d = step_last ? S_RHI : S_WLO;
      S_RHI: begin
        if (to_last) begin
          state_d = S_IDLE;
          fin_err = 1'b1;
        end else if (ph_last) begin
          state_d = S_RLO;
        end
      end
      S_RLO: begin
        if (ph_last && have_prev_q && (flash_dq_i[6] == prev6_q)) begin
          state_d = S_IDLE;
          fin_ok  = 1'b1;
        end else if (to_last) begin
          state_d = S_IDLE;
          fin_err = 1'b1;
        end else if (ph_last) begin
          state_d = S_RHI;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      op_q        <= OP_PROG;
      addr_q      <= '0;
      data_q      <= '0;
      step_q      <= '0;
      prev6_q     <= 1'b0;
      have_prev_q <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin_ok | fin_err;
      err_q   <= fin_err;
      if (state_q == S_IDLE && req_valid_i) begin
        op_q   <= req_op_i;
        addr_q <= req_addr_i;
        data_q <= req_data_i;
        step_q <= '0;
      end
      if (state_q == S_WHI && ph_last && !step_last) step_q <= step_q + STEP_W'(1);
      if (to_start) have_prev_q <= 1'b0;
      if (state_q == S_RLO && ph_last) begin
        prev6_q     <= flash_dq_i[6];
        have_prev_q <= 1'b1;
      end
    end
  end

  assign req_ready_o   = (state_q == S_IDLE);
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign flash_we_no   = (state_q != S_WLO);
  assign flash_oe_no   = (state_q != S_RLO);
  assign flash_ce_no   = !((state_q == S_WLO) || (state_q == S_RLO));
  assign flash_dq_oe_o = (state_q == S_WLO) || (state_q == S_WHI);
  assign flash_addr_o  = flash_dq_oe_o ? step_addr : addr_q;
  assign flash_dq_o    = step_data;

  // R5
  oe_we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_we_no |-> (flash_oe_no && !flash_ce_no));
  // R5
  wr_bus_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flash_we_no && $past(!flash_we_no)) |-> ($stable(flash_addr_o) && $stable(flash_dq_o)));
  // R7
  no_contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_oe_no |-> !flash_dq_oe_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  // R10
  ready_bus_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (flash_ce_no && flash_we_no && flash_oe_no));
endmodule

// File: tb/flash_write_seq_tb.sv
module flash_write_seq_tb;
  localparam int WE_LO = 4, WE_HI = 3, OE_LO = 3, OE_HI = 8, TO = 600;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0]  req_op = 2'b00;
  logic [15:0] req_addr = '0, req_data = '0;
  logic done, err, dq_oe, ce_n, oe_n, we_n;
  logic [15:0] f_addr, f_dq_o, f_dq_i;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  flash_write_seq #(.WE_LOW_CYC(WE_LO), .WE_HIGH_CYC(WE_HI), .OE_LOW_CYC(OE_LO),
                    .OE_HIGH_CYC(OE_HI), .TIMEOUT_CYC(TO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_data_i(req_data),
    .done_o(done), .err_o(err), .flash_addr_o(f_addr), .flash_dq_o(f_dq_o),
    .flash_dq_oe_o(dq_oe), .flash_dq_i(f_dq_i), .flash_ce_no(ce_n),
    .flash_oe_no(oe_n), .flash_we_no(we_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // flash model
  logic [15:0] wr_a [0:7];
  logic [15:0] wr_d [0:7];
  logic [15:0] lo_a, lo_d, poll_a;
  int wr_cnt, rd_cnt, busy_left, we_lo_run, we_hi_run, oe_lo_run, oe_hi_run;
  logic first_wr, first_rd, tgl;

  initial begin
    wr_cnt = 0; rd_cnt = 0; busy_left = 0; we_lo_run = 0; we_hi_run = 0;
    oe_lo_run = 0; oe_hi_run = 0; first_wr = 1; first_rd = 1; tgl = 0; poll_a = '0;
    lo_a = '0; lo_d = '0;
    f_dq_i = 16'hA5A5;
  end

  always @(negedge clk) if (rst_n) begin
    if (!we_n) begin
      if (we_lo_run == 0 && !first_wr) chk("R6 we high gap", 32'(we_hi_run >= WE_HI), 1);
      if (we_lo_run == 0) chk("R5 oe high, ce low in write", {oe_n, ce_n}, 2'b10);
      we_lo_run++;
      lo_a = f_addr; lo_d = f_dq_o;
    end else begin
      if (we_lo_run != 0) begin
        chk("R5 we low width", we_lo_run, WE_LO);
        if (wr_cnt < 8) begin wr_a[wr_cnt] = lo_a; wr_d[wr_cnt] = lo_d; end
        wr_cnt++; first_wr = 0; we_hi_run = 0;
      end
      we_lo_run = 0; we_hi_run++;
    end
    if (!oe_n) begin
      if (oe_lo_run == 0) begin
        if (!first_rd) chk("R7 oe high gap", 32'(oe_hi_run >= OE_HI), 1);
        chk("R7 poll address", f_addr, poll_a);
        chk("R7 ce low in read", ce_n, 0);
        if (busy_left > 0) begin tgl = ~tgl; busy_left--; end
        f_dq_i = {9'h152, tgl, 6'h25};
        rd_cnt++; first_rd = 0;
      end
      oe_lo_run++;
    end else begin
      if (oe_lo_run != 0) begin chk("R7 oe low width", oe_lo_run, OE_LO); oe_hi_run = 0; end
      oe_lo_run = 0; oe_hi_run++;
    end
  end

  function automatic void exp_step(input logic [1:0] op, input int i, input logic [15:0] a,
                                   input logic [15:0] d, output logic [15:0] ea, output logic [15:0] ed);
    case (i)
      0, 3: begin ea = 16'h5555; ed = 16'h00AA; end
      1, 4: begin ea = 16'h2AAA; ed = 16'h0055; end
      2: begin ea = 16'h5555; ed = (op == 2'b00) ? 16'h00A0 : 16'h0080; end
      default: begin ea = 16'h5555; ed = (op == 2'b01) ? 16'h0030 : 16'h0010; end
    endcase
    if (op == 2'b00 && i == 3) begin ea = a; ed = d; end
  endfunction

  task automatic run_op(input string tag, input logic [1:0] op, input logic [15:0] a,
                        input logic [15:0] d, input int busy, input bit exp_err, input bit hold);
    int n;
    int nw;
    logic [15:0] ea, ed;
    wr_cnt = 0; rd_cnt = 0; busy_left = busy; first_wr = 1; first_rd = 1;
    we_hi_run = 0; oe_hi_run = 0; poll_a = a;
    @(negedge clk);
    chk({"R10 ready before ", tag}, req_ready, 1);
    req_valid = 1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    if (hold) begin
      req_op = 2'b01; req_addr = 16'h0F0F; req_data = 16'h0000;
      for (int k = 0; k < 20; k++) begin
        chk("R10 ready low while busy", req_ready, 0);
        @(negedge clk);
      end
    end
    req_valid = 0;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk({"R8 done seen ", tag}, done, 1);
    chk({"R9 err flag ", tag}, err, exp_err);
    @(negedge clk);
    chk("R8 done one cycle", done, 0);
    chk("R10 ready after done", req_ready, 1);
    nw = (op == 2'b00) ? 4 : 6;
    chk({"R2 R3 R4 write count ", tag}, wr_cnt, nw);
    for (int i = 0; i < nw && i < wr_cnt; i++) begin
      exp_step(op, i, a, d, ea, ed);
      chk({"R2 R3 R4 write addr ", tag}, wr_a[i], ea);
      chk({"R2 R3 R4 write data ", tag}, wr_d[i], ed);
    end
    if (!exp_err) chk({"R8 read count ", tag}, rd_cnt, (busy == 0) ? 2 : busy + 1);
    else          chk({"R9 polled until timeout ", tag}, 32'(rd_cnt > 40), 1);
    repeat (5) @(negedge clk);
    chk("R8 no reads after done", oe_n, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ready in reset", req_ready, 1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 strobes idle", {ce_n, oe_n, we_n}, 3'b111);
    chk("R1 bus not driven", dq_oe, 0);
    chk("R1 done/err low", {done, err}, 2'b00);
    chk("R1 ready idle", req_ready, 1);
  endtask

  task automatic t_program();
    run_op("R2 program", 2'b00, 16'h3C41, 16'hBEEF, 5, 0, 1);
    run_op("R2 program no busy", 2'b00, 16'h1FFF, 16'h0000, 0, 0, 0);
  endtask

  task automatic t_erase_main();
    run_op("R3 main erase", 2'b01, 16'h8000, 16'h0000, 12, 0, 0);
  endtask

  task automatic t_erase_chip();
    run_op("R4 chip erase op2", 2'b10, 16'h0000, 16'h0000, 3, 0, 0);
    run_op("R4 chip erase op3", 2'b11, 16'h4444, 16'h1234, 1, 0, 0);
  endtask

  task automatic t_timeout();
    run_op("R9 timeout", 2'b01, 16'h2222, 16'h0000, 1000, 1, 0);
    run_op("R9 recovery", 2'b00, 16'h7001, 16'h5A5A, 2, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_program();
    t_erase_main();
    t_erase_chip();
    t_timeout();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule